// File: doc/BRIEF.md
# Serial Flash Program Sequencer

This block takes one 32-bit write on a memory-mapped data port and turns it into a full program operation on a serial NOR flash. It first sends a write-enable command in a frame of its own. It then sends one frame with the program opcode, the flash address and the four data bytes. After that it issues status reads, one per frame, until the flash reports that its internal write has finished. For that whole time the data port holds its wait request, so the bus master stalls until the flash is ready for new work.

A separate control port holds three configuration words. The first sets the lane width of the instruction, address and data phases. The second selects 3-byte or 4-byte addressing. The third holds the program opcode and the polling opcode. These words are read back without delay and never stall. The flash clock runs at half the system clock in SPI mode 0, and each phase drives either one lane or four lanes.

Top module: `sflash_prog_seq`

## Requirements
- R1: While reset is held, cs_n is 1, sck is 0, dq_oe is 0 and mem_waitreq is 1. Every configuration offset reads 0.
- R2: The settings word at offset 0x0 stores lane fields at bits [1:0] (instruction), [5:4] (address) and [9:8] (data). The control word at offset 0x4 stores bit 8. The opcode word at offset 0x8 stores bits [15:0]. All other bits, and any other offset, read as 0. Writes take effect in the cycle they are presented, and reads are combinational.
- R3: Each data-port write starts with a chip-select frame that carries only the 8-bit opcode 06h, at the instruction lane width.
- R4: The next frame carries the program opcode (opcode word bits [7:0]), then the address, then 32 data bits, all under one chip select and with no extra clocks.
- R5: A lane field of 2 selects quad mode: one nibble per flash clock on dq_out[3:0], with bit 3 the most significant, and dq_oe = 4'hF. Any other field value selects single mode: one bit per clock on dq_out[0], dq_oe = 4'h1, and status input on dq_in[1]. Each phase follows its own field. The polling command and the status read use the instruction width. During the status read, dq_oe is 0 and quad input is taken from dq_in[3:0].
- R6: With control bit 8 equal to 0, the address phase sends mem_addr[23:0] as 24 bits. With bit 8 equal to 1, it sends all 32 bits of mem_addr. The most significant bit goes first in both cases.
- R7: The data phase sends mem_wdata[7:0] first, then [15:8], [23:16] and [31:24]. Each byte goes MSB first.
- R8: After the program frame, each polling frame sends the polling opcode (opcode word bits [15:8]) and then reads 8 status bits. Polling frames repeat until the done rule holds.
- R9: When the polling opcode is 70h, a status byte with bit 7 equal to 1 means the write is done. For any other polling opcode, a status byte with bit 0 equal to 0 means done.
- R10: mem_waitreq stays 1 from the start of a write until the final polling frame has closed. It then drops to 0 for exactly one cycle, with cs_n already 1.
- R11: sck is 0 whenever cs_n is 1. Each flash clock lasts two system cycles. dq_out holds steady across every rising edge of sck.
- R12: Between any two frames, cs_n stays 1 for at least GAP_CYC system cycles (default 2, which is one flash clock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | CFG_AW | Configuration byte offset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, combinational |
| mem_addr | input | 32 | Flash byte address of the program |
| mem_wr | input | 1 | Program write request |
| mem_wdata | input | 32 | Word to program |
| mem_waitreq | output | 1 | Stall for the data port; low for one cycle at completion |
| sck | output | 1 | Flash clock, idle low |
| cs_n | output | 1 | Flash chip select, active low |
| dq_out | output | 4 | Flash data lanes, output value |
| dq_oe | output | 4 | Output enable per lane |
| dq_in | input | 4 | Flash data lanes, input value |

## Verification
The bench builds the block with its default parameters: a 4-bit configuration offset, a two-cycle deselect gap, 06h as the write-enable opcode and 70h as the opcode that selects the bit-7 done rule. With these values, the programmed polling opcode alone decides which done rule applies. The bench therefore reaches both rules by changing only the opcode word, for example 70h against 05h. It also uses status bytes in which only the relevant bit decides the outcome. A gap of two cycles makes the deselect time exactly one flash clock, so the minimum gap the bench measures sits right at the bound. It drives single, quad and mixed lane settings with both address lengths.

// File: rtl/sflash_prog_seq.sv
module sflash_prog_seq #(
  parameter int          CFG_AW       = 4,
  parameter int          GAP_CYC      = 2,
  parameter logic [7:0]  WREN_OP      = 8'h06,
  parameter logic [7:0]  DONE_FLAG_OP = 8'h70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [31:0]       mem_addr,
  input  logic              mem_wr,
  input  logic [31:0]       mem_wdata,
  output logic              mem_waitreq,
  output logic              sck,
  output logic              cs_n,
  output logic [3:0]        dq_out,
  output logic [3:0]        dq_oe,
  input  logic [3:0]        dq_in
);

  localparam int HW = $clog2(GAP_CYC + 1);

  typedef enum logic [2:0] {IDLE, WREN, CMD, ADDR, DATA, POLL_CMD, POLL_READ, DONE} st_t;

  st_t          state;
  logic [1:0]   lane_i, lane_a, lane_d;
  logic         addr4;
  logic [7:0]   prog_op, poll_op;
  logic [31:0]  a_q, d_q, sh, nxt;
  logic [5:0]   rem, step;
  logic [HW-1:0] hold;
  logic         ph, cur_q, last, done_hit;
  logic         unused_hi;

  assign unused_hi = ^cfg_wdata[31:16];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_i  <= '0;
      lane_a  <= '0;
      lane_d  <= '0;
      addr4   <= 1'b0;
      prog_op <= '0;
      poll_op <= '0;
    end else if (cfg_wr) begin
      if (cfg_addr == CFG_AW'(0)) begin
        lane_i <= cfg_wdata[1:0];
        lane_a <= cfg_wdata[5:4];
        lane_d <= cfg_wdata[9:8];
      end
      if (cfg_addr == CFG_AW'(4)) addr4 <= cfg_wdata[8];
      if (cfg_addr == CFG_AW'(8)) begin
        prog_op <= cfg_wdata[7:0];
        poll_op <= cfg_wdata[15:8];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == CFG_AW'(0)) cfg_rdata = {22'h0, lane_d, 2'b00, lane_a, 2'b00, lane_i};
    if (cfg_addr == CFG_AW'(4)) cfg_rdata = {23'h0, addr4, 8'h00};
    if (cfg_addr == CFG_AW'(8)) cfg_rdata = {16'h0, poll_op, prog_op};
  end

  assign cur_q    = (state == ADDR) ? (lane_a == 2'd2) :
                    (state == DATA) ? (lane_d == 2'd2) : (lane_i == 2'd2);
  assign step     = cur_q ? 6'd4 : 6'd1;
  assign last     = (rem == step);
  assign nxt      = cur_q ? {sh[27:0], dq_in} : {sh[30:0], dq_in[1]};
  assign done_hit = (poll_op == DONE_FLAG_OP) ? nxt[7] : ~nxt[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE;
      sh    <= '0;
      rem   <= '0;
      ph    <= 1'b0;
      hold  <= '0;
      a_q   <= '0;
      d_q   <= '0;
    end else begin
      case (state)
        IDLE: if (mem_wr) begin
          a_q   <= mem_addr;
          d_q   <= mem_wdata;
          sh    <= {WREN_OP, 24'h0};
          rem   <= 6'd8;
          hold  <= HW'(GAP_CYC);
          state <= WREN;
        end
        DONE: state <= IDLE;
        default: begin
          if (hold != '0) hold <= hold - 1'b1;
          else if (!ph) ph <= 1'b1;
          else begin
            ph  <= 1'b0;
            sh  <= nxt;
            rem <= rem - step;
            if (last) begin
              case (state)
                WREN: begin
                  state <= CMD;
                  sh    <= {prog_op, 24'h0};
                  rem   <= 6'd8;
                  hold  <= HW'(GAP_CYC);
                end
                CMD: begin
                  state <= ADDR;
                  sh    <= addr4 ? a_q : {a_q[23:0], 8'h0};
                  rem   <= addr4 ? 6'd32 : 6'd24;
                end
                ADDR: begin
                  state <= DATA;
                  sh    <= {d_q[7:0], d_q[15:8], d_q[23:16], d_q[31:24]};
                  rem   <= 6'd32;
                end
                DATA: begin
                  state <= POLL_CMD;
                  sh    <= {poll_op, 24'h0};
                  rem   <= 6'd8;
                  hold  <= HW'(GAP_CYC);
                end
                POLL_CMD: begin
                  state <= POLL_READ;
                  sh    <= '0;
                  rem   <= 6'd8;
                end
                default: begin
                  if (done_hit) state <= DONE;
                  else begin
                    state <= POLL_CMD;
                    sh    <= {poll_op, 24'h0};
                    rem   <= 6'd8;
                    hold  <= HW'(GAP_CYC);
                  end
                end
              endcase
            end
          end
        end
      endcase
    end
  end

  assign sck         = ph;
  assign cs_n        = !((state != IDLE) && (state != DONE) && (hold == '0));
  assign dq_oe       = (cs_n || state == POLL_READ) ? 4'h0 : (cur_q ? 4'hF : 4'h1);
  assign dq_out      = cs_n ? 4'h0 : (cur_q ? sh[31:28] : {3'b000, sh[31]});
  assign mem_waitreq = (state != DONE);

  a_r11_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  a_r11_stable_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !sck) |=> (sck && $stable(dq_out)));

  a_r10_wait_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_waitreq |=> mem_waitreq);

  a_r12_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);

endmodule

// File: tb/sflash_prog_seq_tb_top.sv
module sflash_prog_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] mem_addr = '0;
  logic        mem_wr = 1'b0;
  logic [31:0] mem_wdata = '0;
  logic        mem_waitreq, sck, cs_n;
  logic [3:0]  dq_out, dq_oe;
  logic [3:0]  dq_in = '0;

  always #4 clk = ~clk;

  sflash_prog_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_waitreq(mem_waitreq),
    .sck(sck), .cs_n(cs_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  int n_chk = 0, n_bad = 0;
  int frame = 0, rises = 0;
  logic [3:0] cap_d [0:31][0:79];
  logic [3:0] cap_o [0:31][0:79];
  int frame_len [0:31];
  logic [3:0] last_low = '0;
  int stab_err = 0, sck_err = 0, hi_run = 0, min_gap = 1000;
  bit ever_low = 1'b0;
  int nbusy_t = 0, base_t = 0, ci_t = 8;
  bit qi_t = 1'b0;
  logic [7:0] busy_t = '0, done_t = '0;

  always @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      if (rises != 0) begin
        if (frame < 32) frame_len[frame] = rises;
        frame = frame + 1;
      end
      rises = 0;
    end else begin
      if (frame < 32 && rises < 80) begin
        cap_d[frame][rises] = dq_out;
        cap_o[frame][rises] = dq_oe;
      end
      if (dq_out !== last_low) stab_err++;
      rises = rises + 1;
    end
  end

  always @(negedge clk) begin
    int slot, p;
    logic [7:0] b;
    if (cs_n) begin
      hi_run++;
      if (sck) sck_err++;
    end else begin
      if (ever_low && hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
      hi_run = 0;
      ever_low = 1'b1;
      if (!sck) last_low = dq_out;
    end
    slot = rises - ci_t - (sck ? 1 : 0);
    p = frame - base_t - 2;
    b = (p < nbusy_t) ? busy_t : done_t;
    if (cs_n || slot < 0 || p < 0) dq_in <= 4'h0;
    else if (qi_t) dq_in <= (slot == 0) ? b[7:4] : b[3:0];
    else if (slot < 8) dq_in <= {2'b00, b[7-slot], 1'b0};
    else dq_in <= 4'h0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bits_of(int f, int start, int n, bit q);
    logic [31:0] r = '0;
    int k = start;
    if (q) for (int i = 0; i < n / 4; i++) begin r = {r[27:0], cap_d[f][k]}; k++; end
    else   for (int i = 0; i < n; i++)     begin r = {r[30:0], cap_d[f][k][0]}; k++; end
    return r;
  endfunction

  function automatic int oe_bad(int f, int start, int n, logic [3:0] exp);
    int c = 0;
    for (int i = start; i < start + n; i++) if (cap_o[f][i] !== exp) c++;
    return c;
  endfunction

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [3:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic test_reset;
    logic [31:0] d;
    chk("R1 cs_n in reset", cs_n, 1);
    chk("R1 sck in reset", sck, 0);
    chk("R1 dq_oe in reset", dq_oe, 0);
    chk("R1 waitreq in reset", mem_waitreq, 1);
    for (int a = 0; a < 16; a += 4) begin
      cfg_read(4'(a), d);
      chk("R1 config zero in reset", d, 0);
    end
  endtask

  task automatic test_regs;
    logic [31:0] d;
    cfg_write(4'h0, 32'hFFFF_FFFF); cfg_read(4'h0, d); chk("R2 settings mask", d, 32'h333);
    cfg_write(4'h4, 32'hFFFF_FFFF); cfg_read(4'h4, d); chk("R2 control mask", d, 32'h100);
    cfg_write(4'h8, 32'hFFFF_FFFF); cfg_read(4'h8, d); chk("R2 opcode mask", d, 32'hFFFF);
    cfg_read(4'hC, d); chk("R2 unused offset", d, 0);
    cfg_write(4'h0, 32'h222); cfg_read(4'h0, d); chk("R2 settings value", d, 32'h222);
    cfg_write(4'h4, 32'h101); cfg_read(4'h4, d); chk("R2 control value", d, 32'h100);
    cfg_write(4'h8, 32'h7034); cfg_read(4'h8, d); chk("R2 opcode value", d, 32'h7034);
    chk("R2 no stall on config", mem_waitreq, 1);
  endtask

  task automatic run_txn(input string nm, input logic [31:0] proto, input logic [31:0] ctrl,
                         input logic [31:0] instr, input logic [31:0] addr, input logic [31:0] data,
                         input int nb, input logic [7:0] bb, input logic [7:0] db);
    bit qi, qa, qd, a4;
    int ci, ca, cd, f, bad;
    logic [31:0] ea;
    qi = (proto[1:0] == 2'd2); qa = (proto[5:4] == 2'd2); qd = (proto[9:8] == 2'd2);
    a4 = ctrl[8];
    ci = qi ? 2 : 8;
    ca = (a4 ? 32 : 24) / (qa ? 4 : 1);
    cd = qd ? 8 : 32;
    ea = a4 ? addr : {8'h00, addr[23:0]};
    cfg_write(4'h0, proto); cfg_write(4'h4, ctrl); cfg_write(4'h8, instr);
    nbusy_t = nb; busy_t = bb; done_t = db; base_t = frame; ci_t = ci; qi_t = qi;
    @(negedge clk);
    mem_addr = addr; mem_wdata = data; mem_wr = 1'b1;
    while (mem_waitreq) @(negedge clk);
    chk({"R9 poll count at release ", nm}, frame - base_t, nb + 3);
    chk({"R10 deselected at release ", nm}, cs_n, 1);
    mem_wr = 1'b0;
    @(negedge clk);
    chk({"R10 single-cycle release ", nm}, mem_waitreq, 1);
    f = base_t;
    chk({"R3 wren length ", nm}, frame_len[f], ci);
    chk({"R3 wren opcode ", nm}, bits_of(f, 0, 8, qi), 32'h06);
    chk({"R5 wren lanes ", nm}, oe_bad(f, 0, ci, qi ? 4'hF : 4'h1), 0);
    f = base_t + 1;
    chk({"R4 program length ", nm}, frame_len[f], ci + ca + cd);
    chk({"R4 program opcode ", nm}, bits_of(f, 0, 8, qi), {24'h0, instr[7:0]});
    chk({"R6 address ", nm}, bits_of(f, ci, a4 ? 32 : 24, qa), ea);
    chk({"R7 data order ", nm}, bits_of(f, ci + ca, 32, qd),
        {data[7:0], data[15:8], data[23:16], data[31:24]});
    bad = oe_bad(f, 0, ci, qi ? 4'hF : 4'h1) + oe_bad(f, ci, ca, qa ? 4'hF : 4'h1)
        + oe_bad(f, ci + ca, cd, qd ? 4'hF : 4'h1);
    chk({"R5 program lanes ", nm}, bad, 0);
    for (int p = 0; p <= nb; p++) begin
      f = base_t + 2 + p;
      chk({"R8 poll length ", nm}, frame_len[f], 2 * ci);
      chk({"R8 poll opcode ", nm}, bits_of(f, 0, 8, qi), {24'h0, instr[15:8]});
      chk({"R5 poll lanes ", nm}, oe_bad(f, 0, ci, qi ? 4'hF : 4'h1) + oe_bad(f, ci, ci, 4'h0), 0);
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_regs();
    run_txn("single 3B", 32'h000, 32'h001, 32'h7002, 32'h0000_1000, 32'h1234_abcd, 2, 8'h01, 8'h80);
    run_txn("quad 4B",   32'h222, 32'h101, 32'h7034, 32'h0000_2000, 32'habcd_1234, 1, 8'h7F, 8'h81);
    run_txn("status05",  32'h000, 32'h100, 32'h0512, 32'hA5C3_0F01, 32'h0F1E_2D3C, 3, 8'h01, 8'hFE);
    run_txn("quad addr", 32'h020, 32'h000, 32'h7002, 32'hFF12_3456, 32'h89AB_CDEF, 0, 8'h00, 8'h80);
    run_txn("quad data", 32'h200, 32'h000, 32'h0532, 32'h00AB_CDEF, 32'hDEAD_BEEF, 1, 8'hFF, 8'h00);
    chk("R11 sck low while deselected", sck_err, 0);
    chk("R11 dq_out stable across rise", stab_err, 0);
    chk("R12 deselect gap", (min_gap >= 2) ? 1 : 0, 1);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=complete");
    finish_run();
  end

endmodule